// File: doc/BRIEF.md
# Bidirectional Latched Inverting Bus Transceiver

This block links two parallel ports, A and B, through two separate banks of level-sensitive storage, one per direction. Each direction is steered by three active-low controls: a path select, a latch gate and a drive select. While both the path select and the latch gate are LOW, the bank is open and the opposite port shows the complement of the source port. When either control goes HIGH, the bank closes and keeps the last value it sampled. The stored word is shown, inverted, whenever the direction is driving.

There are no tri-state pins. Each port has a separate input bus, output bus and active-high drive-enable. A disabled output bus reads all zeros. A clash flag rises when both ports are driving at the same time.

Storage is modelled on the clock. An open bank samples its source on every rising edge. Its output is the complement of the source itself while the bank is open, and the complement of the stored word while it is closed.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: The two directions are independent. The controls and input of one direction never change the outputs of the other direction.
- R2: When a direction's path select, latch gate and drive select are all LOW, the destination bus equals the bitwise complement of the source bus in the same cycle.
- R3: The last word sampled at a rising clock edge while the bank was open is captured. This holds whether the bank is closed by the latch gate going HIGH or by the path select going HIGH.
- R4: While a bank is closed, changes on its source bus leave its stored word and its destination bus unchanged.
- R5: A destination drive-enable (`a_oe` or `b_oe`) is 1 exactly when that direction's path select and drive select are both LOW. While the drive-enable is 0, the destination bus reads all zeros.
- R6: With the drive select HIGH, an open bank still samples its source. The stored word appears, inverted, once the drive select returns LOW with the bank closed.
- R7: A closed bank that is driving shows the bitwise complement of its stored word.
- R8: `contention` is 1 exactly when `a_oe` and `b_oe` are both 1.
- R9: Reset (`rst_n` LOW, asynchronous) clears both banks to zero. A driving, closed direction then shows all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Port A input bus (source for A-to-B) |
| a_out | output | WIDTH | Port A output bus (B-to-A destination) |
| a_oe | output | 1 | Port A drive-enable, active high |
| b_in | input | WIDTH | Port B input bus (source for B-to-A) |
| b_out | output | WIDTH | Port B output bus (A-to-B destination) |
| b_oe | output | 1 | Port B drive-enable, active high |
| ab_path_n | input | 1 | A-to-B path select, active low |
| ab_gate_n | input | 1 | A-to-B latch gate, active low |
| ab_drv_n | input | 1 | A-to-B drive select, active low |
| ba_path_n | input | 1 | B-to-A path select, active low |
| ba_gate_n | input | 1 | B-to-A latch gate, active low |
| ba_drv_n | input | 1 | B-to-A drive select, active low |
| contention | output | 1 | Both ports driving at once |

## Verification
Directed sequences close a bank once through the gate and once through the path select. They also change the source in the same cycle as the close. This separates the word sampled at the last open edge from the word present at the close. Other directed cases load a bank with the drive select HIGH and read it later, and toggle one direction's controls while the other holds a known word; these show that storage is kept separate from driving and that the directions do not leak into each other. Random control mixes, with each control biased LOW, cover all eight control combinations per direction along with the clash flag. A reference model built from the requirements predicts every output.

// File: rtl/bidir_latch_xcvr_pkg.sv
package bidir_latch_xcvr_pkg;

   typedef struct packed {
      logic path_n;
      logic gate_n;
      logic drv_n;
   } dir_ctrl_t;

   function automatic logic bank_open(dir_ctrl_t c);
      return (!c.path_n) && (!c.gate_n);
   endfunction

   function automatic logic bank_drives(dir_ctrl_t c);
      return (!c.path_n) && (!c.drv_n);
   endfunction

endpackage

// File: rtl/xcvr_dir_bank.sv
module xcvr_dir_bank
   import bidir_latch_xcvr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dir_ctrl_t        ctrl,
   input  logic [WIDTH-1:0] src,
   output logic [WIDTH-1:0] dst,
   output logic             dst_oe
);

   localparam logic [WIDTH-1:0] ZERO_W = '0;

   logic [WIDTH-1:0] held_q;
   logic [WIDTH-1:0] view;
   logic [WIDTH-1:0] view_pol;
   logic             is_open;
   logic             is_drv;

   assign is_open = bank_open(ctrl);
   assign is_drv  = bank_drives(ctrl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= ZERO_W;
      else if (is_open)
         held_q <= src;
   end

   assign view = is_open ? src : held_q;

   generate
      if (INVERT) begin : g_inv
         assign view_pol = ~view;
      end else begin : g_true
         assign view_pol = view;
      end
   endgenerate

   assign dst    = is_drv ? view_pol : ZERO_W;
   assign dst_oe = is_drv;

endmodule

// File: rtl/xcvr_clash_flag.sv
module xcvr_clash_flag (
   input  logic oe_a,
   input  logic oe_b,
   output logic clash
);
   assign clash = oe_a & oe_b;
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
   import bidir_latch_xcvr_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe,
   input  logic             ab_path_n,
   input  logic             ab_gate_n,
   input  logic             ab_drv_n,
   input  logic             ba_path_n,
   input  logic             ba_gate_n,
   input  logic             ba_drv_n,
   output logic             contention
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bidir_latch_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   dir_ctrl_t ab_ctrl;
   dir_ctrl_t ba_ctrl;

   assign ab_ctrl = '{path_n: ab_path_n, gate_n: ab_gate_n, drv_n: ab_drv_n};
   assign ba_ctrl = '{path_n: ba_path_n, gate_n: ba_gate_n, drv_n: ba_drv_n};

   xcvr_dir_bank #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (ab_ctrl),
      .src    (a_in),
      .dst    (b_out),
      .dst_oe (b_oe)
   );

   xcvr_dir_bank #(.WIDTH(WIDTH), .INVERT(INVERT)) u_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (ba_ctrl),
      .src    (b_in),
      .dst    (a_out),
      .dst_oe (a_oe)
   );

   xcvr_clash_flag u_clash (
      .oe_a  (a_oe),
      .oe_b  (b_oe),
      .clash (contention)
   );

endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
module bidir_latch_xcvr_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe,
   input logic             ab_path_n,
   input logic             ab_gate_n,
   input logic             ab_drv_n,
   input logic             ba_path_n,
   input logic             ba_gate_n,
   input logic             ba_drv_n,
   input logic             contention
);

   assert_ab_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_path_n && !ab_gate_n && !ab_drv_n) |-> (b_out == ~a_in));

   assert_ba_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ba_path_n && !ba_gate_n && !ba_drv_n) |-> (a_out == ~b_in));

   assert_ab_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_gate_n && $past(ab_gate_n) && !ab_drv_n && !$past(ab_drv_n)
       && !ab_path_n && !$past(ab_path_n)) |-> $stable(b_out));

   assert_ab_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_path_n || ab_drv_n) |-> (!b_oe && b_out == '0));

   assert_ba_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_path_n || ba_drv_n) |-> (!a_oe && a_out == '0));

   assert_clash_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe && b_oe) |-> contention);

   assert_clash_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_oe || !b_oe) |-> !contention);

endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .a_in       (a_in),
   .a_out      (a_out),
   .a_oe       (a_oe),
   .b_in       (b_in),
   .b_out      (b_out),
   .b_oe       (b_oe),
   .ab_path_n  (ab_path_n),
   .ab_gate_n  (ab_gate_n),
   .ab_drv_n   (ab_drv_n),
   .ba_path_n  (ba_path_n),
   .ba_gate_n  (ba_gate_n),
   .ba_drv_n   (ba_drv_n),
   .contention (contention)
);

// File: tb/bidir_latch_xcvr_test.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_test;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic a_oe, b_oe, contention;
   logic ab_path_n = 1'b1, ab_gate_n = 1'b1, ab_drv_n = 1'b1;
   logic ba_path_n = 1'b1, ba_gate_n = 1'b1, ba_drv_n = 1'b1;

   int total = 0;
   int bad = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   bidir_latch_xcvr #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .ab_path_n(ab_path_n), .ab_gate_n(ab_gate_n), .ab_drv_n(ab_drv_n),
      .ba_path_n(ba_path_n), .ba_gate_n(ba_gate_n), .ba_drv_n(ba_drv_n),
      .contention(contention)
   );

   // reference storage, updated from the requirements
   logic [W-1:0] ref_ab, ref_ba;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_ab <= '0;
         ref_ba <= '0;
      end else begin
         if (!ab_path_n && !ab_gate_n) ref_ab <= a_in;
         if (!ba_path_n && !ba_gate_n) ref_ba <= b_in;
      end
   end

   function automatic logic [W-1:0] exp_dst(logic pn, logic gn, logic dn,
                                            logic [W-1:0] src, logic [W-1:0] held);
      if (pn || dn) return '0;
      if (!gn) return ~src;
      return ~held;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(string req);
      logic eb, ea;
      eb = !ab_path_n && !ab_drv_n;
      ea = !ba_path_n && !ba_drv_n;
      chk({req, " R1/R5 b_out"}, 32'(b_out), 32'(exp_dst(ab_path_n, ab_gate_n, ab_drv_n, a_in, ref_ab)));
      chk({req, " R1/R5 a_out"}, 32'(a_out), 32'(exp_dst(ba_path_n, ba_gate_n, ba_drv_n, b_in, ref_ba)));
      chk({req, " R5 b_oe"}, 32'(b_oe), 32'(eb));
      chk({req, " R5 a_oe"}, 32'(a_oe), 32'(ea));
      chk({req, " R8 contention"}, 32'(contention), 32'(ea && eb));
   endtask

   task automatic set_ab(logic p, logic g, logic d);
      ab_path_n = p; ab_gate_n = g; ab_drv_n = d;
   endtask
   task automatic set_ba(logic p, logic g, logic d);
      ba_path_n = p; ba_gate_n = g; ba_drv_n = d;
   endtask

   // advance one cycle: wait for next falling edge (posedge passes in between)
   task automatic cyc();
      @(negedge clk);
   endtask

   initial begin : watchdog
      #1_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int unsigned seed;
      seed = 32'd4711;
      void'($urandom(seed));

      // R9 reset state
      cyc(); cyc();
      set_ab(0, 1, 0); set_ba(0, 1, 0);
      #2;
      chk("R9 b_out after reset", 32'(b_out), 32'hFF);
      chk("R9 a_out after reset", 32'(a_out), 32'hFF);
      rst_n = 1'b1;
      cyc();

      // R2 transparent A-to-B
      set_ab(0, 0, 0); a_in = 8'h3C; #2;
      chk("R2 transparent", 32'(b_out), 32'hC3);
      cyc();
      // R3 close via gate, source changes in the same cycle
      set_ab(0, 1, 0); a_in = 8'h81; #2;
      chk("R3 gate close keeps last sampled", 32'(b_out), 32'hC3);
      cyc();
      // R4 source change while closed
      a_in = 8'h55; #2;
      chk("R4 hold ignores source", 32'(b_out), 32'hC3);
      cyc();
      chk("R4 hold after edge", 32'(b_out), 32'hC3);
      cyc();

      // R3 close via path select
      set_ab(0, 0, 0); a_in = 8'h0F; cyc();
      set_ab(1, 0, 0); a_in = 8'hAA; #2;
      chk("R5 path high disables b_oe", 32'(b_oe), 32'h0);
      chk("R5 disabled bus zero", 32'(b_out), 32'h00);
      cyc();
      set_ab(0, 1, 0); #2;
      chk("R3 path close keeps last sampled", 32'(b_out), 32'hF0);
      cyc();

      // R6 load with drive select high, show later; R7 inversion of stored
      set_ab(0, 0, 1); a_in = 8'h96; #2;
      chk("R6 no drive while loading", 32'(b_oe), 32'h0);
      cyc();
      set_ab(0, 1, 1); a_in = 8'h00; cyc();
      set_ab(0, 1, 0); #2;
      chk("R6 stored word shown", 32'(b_out), 32'h69);
      chk("R7 complement of stored", 32'(b_out ^ 8'hFF), 32'h96);
      cyc();

      // R1 independence: toggle B-to-A, A-to-B stays
      set_ba(0, 0, 0); b_in = 8'h12; #2;
      chk("R1 ab unaffected", 32'(b_out), 32'h69);
      chk("R2 ba transparent", 32'(a_out), 32'hED);
      // R8 both drive
      chk("R8 contention both", 32'(contention), 32'h1);
      cyc();
      set_ba(0, 1, 0); b_in = 8'hFF; cyc();
      #2;
      chk("R1 ba stored", 32'(a_out), 32'hED);
      chk("R1 ab still", 32'(b_out), 32'h69);
      set_ba(1, 1, 1); #1;
      chk("R8 contention off", 32'(contention), 32'h0);
      cyc();

      // random phase
      for (int i = 0; i < 3000; i++) begin
         set_ab(($urandom % 10) < 3, ($urandom % 10) < 4, ($urandom % 10) < 3);
         set_ba(($urandom % 10) < 3, ($urandom % 10) < 4, ($urandom % 10) < 3);
         if ($urandom % 2) a_in = W'($urandom);
         if ($urandom % 2) b_in = W'($urandom);
         #2;
         check_all("random");
         cyc();
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule